// File: doc/BRIEF.md
# Incompletely Decoded System Address Decoder

This block turns the 16-bit address of an 8-bit processor into active-low chip selects. Two identical 2-to-4 decoders with active-low outputs are chained. The first decoder takes the phase-2 clock and the top address bit. It separates the upper half of the address space, which goes to the cartridge, from the lower half. Its lower-half output enables the second decoder. The second decoder splits the lower half into four 8 KB regions using address bits 14 and 13.

Address bits that no decoder looks at are ignored on purpose. Small devices therefore repeat across the whole of their region. A 2 KB work RAM is part of the block so that this repetition can be seen at the ports. The RAM uses only address bits 10:0, so each byte answers at four addresses inside $0000–$1FFF. The eight video-controller registers are chosen with address bits 2:0 only, so they repeat every eight bytes across $2000–$3FFF.

Top module: `addr_mirror_decoder`

## Requirements
- R1: After reset, `rdata` reads 0 and holds 0 until the first RAM read.
- R2: While `phi2` is low, every chip select (`cart_sel_n`, `ram_sel_n`, `vreg_sel_n`, `spare_sel_n[1:0]`) is high, whatever the address.
- R3: `cart_sel_n` is low exactly when `phi2` is high and `addr[15]` is 1.
- R4: `ram_sel_n` is low exactly when `phi2` is high and `addr[15:13]` is 3'b000.
- R5: `vreg_sel_n` is low exactly when `phi2` is high and `addr[15:13]` is 3'b001. `vreg_idx` always equals `addr[2:0]`, so the register index repeats every eight bytes.
- R6: `spare_sel_n[0]` is low exactly for `phi2` high with `addr[15:13]` = 3'b010. `spare_sel_n[1]` is low exactly for `phi2` high with `addr[15:13]` = 3'b011.
- R7: At most one chip select is low in any cycle.
- R8: At a rising `clk` edge with `ram_sel_n` low and `cpu_we` high, `wdata` is stored in the RAM byte indexed by `addr[10:0]`.
- R9: Addresses in $0000–$1FFF that differ only in `addr[12:11]` reach the same RAM byte.
- R10: At a rising `clk` edge with `ram_sel_n` low and `cpu_we` low, `rdata` takes the byte at `addr[10:0]`. At any other edge, `rdata` holds its value.
- R11: A write strobe given while `ram_sel_n` is high changes no RAM byte. This holds when `phi2` is low and when the address lies outside $0000–$1FFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for RAM writes and the read register |
| rst_n | input | 1 | Active-low asynchronous reset |
| phi2 | input | 1 | Processor phase-2 clock, qualifies all selects |
| addr | input | 16 | Processor address bus |
| cpu_we | input | 1 | Write strobe, active high |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered RAM read data |
| cart_sel_n | output | 1 | Upper-half cartridge select, active low |
| ram_sel_n | output | 1 | Work RAM select, active low |
| vreg_sel_n | output | 1 | Video-controller register block select, active low |
| vreg_idx | output | 3 | Video-controller register index |
| spare_sel_n | output | 2 | Selects for $4000–$5FFF and $6000–$7FFF, active low |

## Verification
A wrong decode shows on the select pins in the same cycle as the address that causes it. The bench compares every select against a model on every vector, across sweeps of the upper address bits with `phi2` both high and low. A RAM fault has a different shape. A bad write index, missing mirroring or a write that leaks through a closed select stays hidden until that byte is read. So the bench fills the RAM first, writes through mirror aliases and through closed selects, and then reads back. It compares `rdata` one clock after each read edge.

// File: rtl/amd_pkg.sv
package amd_pkg;
    // Index of the first-stage decoder outputs
    localparam int unsigned STG1_LOW_HALF  = 1;
    localparam int unsigned STG1_HIGH_HALF = 3;
    // Index of the second-stage decoder outputs
    localparam int unsigned STG2_RAM   = 0;
    localparam int unsigned STG2_VREG  = 1;
    localparam int unsigned STG2_SPARE0 = 2;
    localparam int unsigned STG2_SPARE1 = 3;

    typedef struct packed {
        logic cart_n;
        logic ram_n;
        logic vreg_n;
        logic [1:0] spare_n;
    } sel_bus_t;
endpackage

// File: rtl/amd_dec2to4.sv
module amd_dec2to4 (
    input  logic       en_n,
    input  logic       in_a,
    input  logic       in_b,
    output logic [3:0] out_n
);
    logic [1:0] code;
    assign code = {in_b, in_a};

    for (genvar g = 0; g < 4; g++) begin : g_out
        assign out_n[g] = en_n | (code != 2'(g));
    end
endmodule

// File: rtl/amd_work_ram.sv
module amd_work_ram #(
    parameter int unsigned IDX_W  = 11,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << IDX_W;

    typedef struct packed {
        logic              do_write;
        logic [IDX_W-1:0]  widx;
        logic [DATA_W-1:0] wbyte;
        logic [DATA_W-1:0] rdata;
    } ram_state_t;

    logic [DATA_W-1:0] store [DEPTH];
    ram_state_t st_d;
    logic [DATA_W-1:0] rdata_q;

    always_comb begin
        st_d          = '0;
        st_d.rdata    = rdata_q;
        st_d.widx     = idx;
        st_d.wbyte    = wdata;
        st_d.do_write = !sel_n && we;
        if (!sel_n && !we) begin
            st_d.rdata = store[idx];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= st_d.rdata;
        end
    end

    always_ff @(posedge clk) begin
        if (st_d.do_write) begin
            store[st_d.widx] <= st_d.wbyte;
        end
    end

    assign rdata = rdata_q;

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && we) |=> store[$past(idx)] == $past(wdata)); // R8
    AST_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_n || we) |=> $stable(rdata_q)); // R10
endmodule

// File: rtl/addr_mirror_decoder.sv
module addr_mirror_decoder #(
    parameter int unsigned ADDR_W  = 16,
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned RAM_IDX_W = 11,
    parameter int unsigned REG_IDX_W = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 phi2,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 cpu_we,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rdata,
    output logic                 cart_sel_n,
    output logic                 ram_sel_n,
    output logic                 vreg_sel_n,
    output logic [REG_IDX_W-1:0] vreg_idx,
    output logic [1:0]           spare_sel_n
);
    import amd_pkg::*;

    localparam int unsigned TOP_BIT = ADDR_W - 1;
    localparam int unsigned MID_BIT = ADDR_W - 2;
    localparam int unsigned LOW_BIT = ADDR_W - 3;

    logic [3:0] stg1_n;
    logic [3:0] stg2_n;
    sel_bus_t   sel_d;

    amd_dec2to4 u_stage1 (
        .en_n  (1'b0),
        .in_a  (phi2),
        .in_b  (addr[TOP_BIT]),
        .out_n (stg1_n)
    );

    amd_dec2to4 u_stage2 (
        .en_n  (stg1_n[STG1_LOW_HALF]),
        .in_a  (addr[LOW_BIT]),
        .in_b  (addr[MID_BIT]),
        .out_n (stg2_n)
    );

    always_comb begin
        sel_d         = '1;
        sel_d.cart_n  = stg1_n[STG1_HIGH_HALF];
        sel_d.ram_n   = stg2_n[STG2_RAM];
        sel_d.vreg_n  = stg2_n[STG2_VREG];
        sel_d.spare_n = {stg2_n[STG2_SPARE1], stg2_n[STG2_SPARE0]};
    end

    assign cart_sel_n  = sel_d.cart_n;
    assign ram_sel_n   = sel_d.ram_n;
    assign vreg_sel_n  = sel_d.vreg_n;
    assign spare_sel_n = sel_d.spare_n;
    assign vreg_idx    = addr[REG_IDX_W-1:0];

    amd_work_ram #(
        .IDX_W  (RAM_IDX_W),
        .DATA_W (DATA_W)
    ) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .sel_n (ram_sel_n),
        .we    (cpu_we),
        .idx   (addr[RAM_IDX_W-1:0]),
        .wdata (wdata),
        .rdata (rdata)
    );

    AST_IDLE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        !phi2 |-> (cart_sel_n && ram_sel_n && vreg_sel_n && (&spare_sel_n))); // R2
    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({~cart_sel_n, ~ram_sel_n, ~vreg_sel_n, ~spare_sel_n}) <= 1); // R7
    AST_CART_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        !cart_sel_n |-> addr[TOP_BIT]); // R3
    AST_RAM_REGION: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_sel_n |-> (addr[TOP_BIT:LOW_BIT] == 3'b000)); // R4
    AST_VREG_REGION: assert property (@(posedge clk) disable iff (!rst_n)
        !vreg_sel_n |-> (addr[TOP_BIT:LOW_BIT] == 3'b001)); // R5
    AST_STAGE2_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        stg1_n[STG1_LOW_HALF] |-> (&stg2_n)); // R6
endmodule

// File: tb/tb_addr_mirror_decoder.sv
module tb_addr_mirror_decoder;
    localparam int CLK_HALF = 5;
    localparam int WATCHDOG = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        phi2 = 1'b0;
    logic [15:0] addr = '0;
    logic        cpu_we = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        cart_sel_n, ram_sel_n, vreg_sel_n;
    logic [2:0]  vreg_idx;
    logic [1:0]  spare_sel_n;

    int vectors = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 0;

    int model_mem [2048];
    int model_rdata = 0;

    addr_mirror_decoder dut (
        .clk(clk), .rst_n(rst_n), .phi2(phi2), .addr(addr), .cpu_we(cpu_we),
        .wdata(wdata), .rdata(rdata), .cart_sel_n(cart_sel_n), .ram_sel_n(ram_sel_n),
        .vreg_sel_n(vreg_sel_n), .vreg_idx(vreg_idx), .spare_sel_n(spare_sel_n)
    );

    always #(CLK_HALF) clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles == WATCHDOG && !done) begin
            fails++;
            $display("FAIL watchdog: act=%0d cycles exp=<%0d", cycles, WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic check(string req, int act, int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: act=%0h exp=%0h addr=%04h phi2=%0b", req, act, exp, addr, phi2);
        end
    endtask

    function automatic bit region(logic [15:0] a, int code);
        return a[15:13] == 3'(code);
    endfunction

    // One bus cycle: drive at negedge, check selects, then check read data after the edge
    task automatic step(bit p2, logic [15:0] a, bit we, logic [7:0] d);
        bit ram_on;
        @(negedge clk);
        phi2 = p2; addr = a; cpu_we = we; wdata = d;
        #1;
        ram_on = p2 && region(a, 0);
        if (!p2) begin
            check("R2", {cart_sel_n, ram_sel_n, vreg_sel_n, spare_sel_n}, 5'b11111);
        end
        check("R3", cart_sel_n, !(p2 && a[15]));
        check("R4", ram_sel_n, !ram_on);
        check("R5", vreg_sel_n, !(p2 && region(a, 1)));
        check("R5", vreg_idx, a[2:0]);
        check("R6", spare_sel_n[0], !(p2 && region(a, 2)));
        check("R6", spare_sel_n[1], !(p2 && region(a, 3)));
        check("R7", (!cart_sel_n) + (!ram_sel_n) + (!vreg_sel_n) + (!spare_sel_n[0]) + (!spare_sel_n[1]) <= 1, 1);
        @(posedge clk);
        if (ram_on && we) model_mem[a[10:0]] = d;
        else if (ram_on) model_rdata = model_mem[a[10:0]];
        #1;
        check("R10", rdata, model_rdata);
    endtask

    initial begin
        for (int i = 0; i < 2048; i++) model_mem[i] = 0;
        repeat (3) @(negedge clk);
        #1;
        check("R1", rdata, 0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check("R1", rdata, 0);

        // R8: fill the whole RAM through the base window
        for (int i = 0; i < 2048; i++) step(1, 16'(i), 1, 8'((i * 7 + 3) & 8'hFF));
        for (int i = 0; i < 2048; i += 97) step(1, 16'(i), 0, 8'h00);

        // R9: write via each mirror, read via a different one
        for (int m = 0; m < 4; m++) begin
            for (int k = 0; k < 16; k++) begin
                logic [15:0] base = 16'((k * 131) & 16'h07FF);
                step(1, base | 16'(m << 11), 1, 8'(8'hA0 + m * 16 + k));
                step(1, base | 16'(((m + 1) % 4) << 11), 0, 8'h00);
                check("R9", rdata, 8'(8'hA0 + m * 16 + k));
            end
        end

        // R11: strobes with the RAM select closed leave RAM untouched
        step(0, 16'h0040, 1, 8'h5A);
        step(1, 16'h2040, 1, 8'h5B);
        step(1, 16'h4840, 1, 8'h5C);
        step(1, 16'h8040, 1, 8'h5D);
        step(1, 16'h0040, 0, 8'h00);
        check("R11", rdata, model_mem[16'h0040]);
        step(0, 16'h0041, 0, 8'h00);
        check("R10", rdata, model_mem[16'h0040]);

        // R2..R7: sweep every upper nibble and register mirrors, both phases
        for (int n = 0; n < 16; n++) begin
            for (int p = 0; p < 2; p++) begin
                step(p[0], 16'((n << 12) | 16'h0ABD), 0, 8'h00);
                step(p[0], 16'((n << 12) | 16'h0003), 1, 8'(n));
            end
        end
        for (int r = 16'h2000; r < 16'h4000; r += 16'h0209) step(1, 16'(r), 0, 8'h00);

        // Mixed random traffic
        for (int i = 0; i < 6000; i++) begin
            logic [15:0] a = 16'($urandom);
            if ($urandom_range(0, 2) == 0) a[15:13] = 3'b000;
            step(1'($urandom_range(0, 3) != 0), a, 1'($urandom_range(0, 1)), 8'($urandom));
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule